// File: doc/BRIEF.md
# Timer Read-Back Command Unit

This block adds a read-back path to a three-channel interval timer. A single write to the timer's control address can capture a snapshot of the count, of the status, or of both, for any subset of the three channels. The status snapshot packs the channel's output pin level and its null-count flag with the six configuration bits last programmed into that channel.

Reads from a channel's data address are then steered through this unit. A latched status byte is returned first. The latched count comes next, in the byte order given by the channel's access format. When nothing is latched, the live count is returned in the same format. The counters keep running while snapshots are held, so a latched value can be read without disturbing the countdown. Decoding of ordinary mode words and the counters themselves live outside this block; their configuration, flags and counts arrive as inputs.

Top module: `timer_readback`

## Requirements
- R1: After reset no snapshot is held for any channel, and the first read of a channel returns the low byte of its live count when its format is low-then-high.
- R2: A control write is a read-back command only when bits 7:6 are 11 and bit 0 is 0. Any other control write latches nothing, and a command with both bit 5 and bit 4 set latches nothing.
- R3: Command bits 1, 2 and 3 select channels 0, 1 and 2. One command latches every selected channel in the same cycle.
- R4: Command bit 5 = 0 stores a snapshot of each selected channel's count. Reads return that snapshot even while the live count changes.
- R5: Command bit 4 = 0 stores a status byte for each selected channel: bit 7 is the output level, bit 6 is the null-count flag, and bits 5:0 are the channel's configuration bits (5:4 access format, 3:1 mode, 0 BCD).
- R6: When a channel holds both snapshots, the next read returns the status byte, and the reads after it return the count.
- R7: The count byte order follows configuration bits 5:4. 01 gives the high byte only, 10 gives the low byte only, and 11 or 00 gives the low byte, then the high byte. A count snapshot is released after its last byte has been read.
- R8: A status or count latch request for a channel that still holds an unread snapshot of the same kind is ignored, and the held value is kept.
- R9: A read addressed to channel index 3 returns 0 and changes no channel state.
- R10: Reads of a channel with no snapshot return its live count in the format of R7. A channel whose format is low-byte-only returns the low byte on every read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Write strobe for the control address |
| cmd_i | input | 8 | Control byte written |
| cfg_i | input | 18 | Per-channel configuration, 6 bits each, channel 0 in bits 5:0 |
| null_cnt_i | input | 3 | Per-channel null-count flag |
| out_lvl_i | input | 3 | Per-channel output pin level |
| count_i | input | 48 | Per-channel live count, 16 bits each, channel 0 lowest |
| rd_en_i | input | 1 | Read strobe on a channel data address; consumes one byte |
| rd_ch_i | input | 2 | Channel addressed by the read |
| rd_data_o | output | 8 | Byte returned for the addressed channel |

## Verification
A latch command takes effect at the clock edge on which it is written, so the snapshot appears at `rd_data_o` from the cycle after that edge. Read data is a combinational view of registered state. The addressed byte is therefore visible in the same cycle as the read strobe, and the following byte is visible only after the edge that consumes it. The bench drives every strobe just after a falling edge and samples `rd_data_o` 1 ns later, before the consuming rising edge. While snapshots are held, it changes the live counts and flag inputs so that the snapshot values can be told apart from the live ones.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  localparam int unsigned RB_NUM_CH = 3;
  localparam int unsigned RB_CNT_W  = 16;
  localparam int unsigned RB_CFG_W  = 6;
  localparam int unsigned RB_BYTE_W = 8;

  typedef logic [RB_BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    FMT_DUAL0 = 2'b00,
    FMT_HI    = 2'b01,
    FMT_LO    = 2'b10,
    FMT_DUAL  = 2'b11
  } fmt_e;

  localparam logic [1:0] RB_OPCODE = 2'b11;
endpackage

// File: rtl/rbk_decode.sv
module rbk_decode #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_i,
  output logic [NUM_CH-1:0] lat_cnt_o,
  output logic [NUM_CH-1:0] lat_sts_o
);
  import rbk_pkg::*;

  logic              is_rb;
  logic [NUM_CH-1:0] sel;

  assign is_rb = cmd_we_i && (cmd_i[7:6] == RB_OPCODE) && !cmd_i[0];
  assign sel   = cmd_i[NUM_CH:1];

  always_comb begin
    lat_cnt_o = '0;
    lat_sts_o = '0;
    if (is_rb) begin
      if (!cmd_i[5]) lat_cnt_o = sel;
      if (!cmd_i[4]) lat_sts_o = sel;
    end
  end
endmodule

// File: rtl/rbk_chan.sv
module rbk_chan #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CFG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lat_cnt_i,
  input  logic             lat_sts_i,
  input  logic             rd_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             null_i,
  input  logic             out_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [7:0]       byte_o,
  output logic             sts_vld_o,
  output logic             cnt_vld_o,
  output logic [7:0]       sts_o,
  output logic [CNT_W-1:0] snap_o
);
  import rbk_pkg::*;

  localparam int unsigned HALF = CNT_W / 2;

  logic             sts_vld_q, cnt_vld_q, hi_q;
  logic [7:0]       sts_q;
  logic [CNT_W-1:0] snap_q;
  fmt_e             fmt;
  logic             two_byte;
  logic [CNT_W-1:0] cur;
  logic [7:0]       cnt_byte;

  assign fmt      = fmt_e'(cfg_i[CFG_W-1 -: 2]);
  assign two_byte = (fmt == FMT_DUAL) || (fmt == FMT_DUAL0);
  assign cur      = cnt_vld_q ? snap_q : count_i;

  always_comb begin
    unique case (fmt)
      FMT_HI:  cnt_byte = cur[CNT_W-1 -: HALF];
      FMT_LO:  cnt_byte = cur[HALF-1:0];
      default: cnt_byte = hi_q ? cur[CNT_W-1 -: HALF] : cur[HALF-1:0];
    endcase
  end

  assign byte_o = sts_vld_q ? sts_q : cnt_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_vld_q <= 1'b0;
      cnt_vld_q <= 1'b0;
      hi_q      <= 1'b0;
      sts_q     <= '0;
      snap_q    <= '0;
    end else begin
      if (rd_i) begin
        if (sts_vld_q) begin
          sts_vld_q <= 1'b0;
        end else begin
          if (two_byte) hi_q <= ~hi_q;
          if (cnt_vld_q && (!two_byte || hi_q)) cnt_vld_q <= 1'b0;
        end
      end
      // new requests land only on an empty holder
      if (lat_sts_i && !sts_vld_q) begin
        sts_q     <= {out_i, null_i, cfg_i};
        sts_vld_q <= 1'b1;
      end
      if (lat_cnt_i && !cnt_vld_q) begin
        snap_q    <= count_i;
        cnt_vld_q <= 1'b1;
      end
    end
  end

  assign sts_vld_o = sts_vld_q;
  assign cnt_vld_o = cnt_vld_q;
  assign sts_o     = sts_q;
  assign snap_o    = snap_q;
endmodule

// File: rtl/rbk_rdmux.sv
module rbk_rdmux #(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned CH_IDX_W = 2
) (
  input  logic                   rd_en_i,
  input  logic [CH_IDX_W-1:0]    rd_ch_i,
  input  logic [NUM_CH-1:0][7:0] ch_byte_i,
  output logic [NUM_CH-1:0]      rd_hit_o,
  output logic [7:0]             rd_data_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign rd_hit_o[g] = rd_en_i && (rd_ch_i == CH_IDX_W'(g));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch_i == CH_IDX_W'(i)) rd_data_o = ch_byte_i[i];
    end
  end
endmodule

// File: rtl/timer_readback.sv
module timer_readback #(
  parameter int unsigned NUM_CH = rbk_pkg::RB_NUM_CH,
  parameter int unsigned CNT_W  = rbk_pkg::RB_CNT_W,
  parameter int unsigned CFG_W  = rbk_pkg::RB_CFG_W,
  localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_we_i,
  input  logic [7:0]                cmd_i,
  input  logic [NUM_CH*CFG_W-1:0]   cfg_i,
  input  logic [NUM_CH-1:0]         null_cnt_i,
  input  logic [NUM_CH-1:0]         out_lvl_i,
  input  logic [NUM_CH*CNT_W-1:0]   count_i,
  input  logic                      rd_en_i,
  input  logic [CH_IDX_W-1:0]       rd_ch_i,
  output logic [7:0]                rd_data_o
);
  logic [NUM_CH-1:0]            lat_cnt, lat_sts, rd_hit;
  logic [NUM_CH-1:0]            sts_vld, cnt_vld;
  logic [NUM_CH-1:0][7:0]       ch_byte, sts_byte;
  logic [NUM_CH-1:0][CNT_W-1:0] snap;

  rbk_decode #(.NUM_CH(NUM_CH)) u_dec (
    .cmd_we_i  (cmd_we_i),
    .cmd_i     (cmd_i),
    .lat_cnt_o (lat_cnt),
    .lat_sts_o (lat_sts)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    rbk_chan #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lat_cnt_i (lat_cnt[g]),
      .lat_sts_i (lat_sts[g]),
      .rd_i      (rd_hit[g]),
      .cfg_i     (cfg_i[g*CFG_W +: CFG_W]),
      .null_i    (null_cnt_i[g]),
      .out_i     (out_lvl_i[g]),
      .count_i   (count_i[g*CNT_W +: CNT_W]),
      .byte_o    (ch_byte[g]),
      .sts_vld_o (sts_vld[g]),
      .cnt_vld_o (cnt_vld[g]),
      .sts_o     (sts_byte[g]),
      .snap_o    (snap[g])
    );
  end

  rbk_rdmux #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_mux (
    .rd_en_i   (rd_en_i),
    .rd_ch_i   (rd_ch_i),
    .ch_byte_i (ch_byte),
    .rd_hit_o  (rd_hit),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/rbk_checker.sv
module rbk_checker #(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CFG_W    = 6,
  parameter int unsigned CH_IDX_W = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cmd_we_i,
  input logic [7:0]                cmd_i,
  input logic [NUM_CH*CFG_W-1:0]   cfg_i,
  input logic [NUM_CH-1:0]         null_cnt_i,
  input logic [NUM_CH-1:0]         out_lvl_i,
  input logic [NUM_CH*CNT_W-1:0]   count_i,
  input logic                      rd_en_i,
  input logic [CH_IDX_W-1:0]       rd_ch_i,
  input logic [7:0]                rd_data_o,
  input logic [NUM_CH-1:0]         sts_vld,
  input logic [NUM_CH-1:0]         cnt_vld,
  input logic [NUM_CH-1:0][7:0]    sts_byte,
  input logic [NUM_CH-1:0][CNT_W-1:0] snap
);
  localparam logic [CH_IDX_W-1:0] LAST_CH = CH_IDX_W'(NUM_CH - 1);

  logic rb_ok, bad_rd;
  assign rb_ok  = cmd_we_i && (cmd_i[7:6] == 2'b11) && !cmd_i[0];
  assign bad_rd = rd_ch_i > LAST_CH;

  p_illegal_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !rb_ok |=> ((sts_vld & ~$past(sts_vld)) == '0) &&
                           ((cnt_vld & ~$past(cnt_vld)) == '0));

  p_bad_ch_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_rd |-> rd_data_o == 8'h00);

  p_bad_ch_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && bad_rd && !cmd_we_i |=> $stable(sts_vld) && $stable(cnt_vld));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic hit;
    assign hit = rd_en_i && (rd_ch_i == CH_IDX_W'(g));

    p_sts_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rb_ok && cmd_i[g+1] && !cmd_i[4] && !sts_vld[g] |=>
        sts_vld[g] && (sts_byte[g] == {$past(out_lvl_i[g]), $past(null_cnt_i[g]),
                                       $past(cfg_i[g*CFG_W +: CFG_W])}));

    p_cnt_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rb_ok && cmd_i[g+1] && !cmd_i[5] && !cnt_vld[g] |=>
        cnt_vld[g] && (snap[g] == $past(count_i[g*CNT_W +: CNT_W])));

    p_sts_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_vld[g] |=> $stable(sts_byte[g]));

    p_cnt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_vld[g] |=> $stable(snap[g]));

    p_sts_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && sts_vld[g] && cnt_vld[g] |=> !sts_vld[g] && cnt_vld[g]);
  end
endmodule

bind timer_readback rbk_checker #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .CFG_W(CFG_W), .CH_IDX_W(CH_IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_we_i   (cmd_we_i),
  .cmd_i      (cmd_i),
  .cfg_i      (cfg_i),
  .null_cnt_i (null_cnt_i),
  .out_lvl_i  (out_lvl_i),
  .count_i    (count_i),
  .rd_en_i    (rd_en_i),
  .rd_ch_i    (rd_ch_i),
  .rd_data_o  (rd_data_o),
  .sts_vld    (sts_vld),
  .cnt_vld    (cnt_vld),
  .sts_byte   (sts_byte),
  .snap       (snap)
);

// File: tb/tb_timer_readback.sv
`timescale 1ns/1ps
module tb_timer_readback;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic [17:0] cfg_i;
  logic [2:0]  null_cnt_i;
  logic [2:0]  out_lvl_i;
  logic [47:0] count_i;
  logic        rd_en_i = 1'b0;
  logic [1:0]  rd_ch_i = '0;
  logic [7:0]  rd_data_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // ch0: fmt 11 mode 2 bin; ch1: fmt 10 mode 3 bcd; ch2: fmt 01 mode 0 bin
  localparam logic [17:0] CFG_SET  = {6'h10, 6'h27, 6'h34};
  localparam logic [47:0] CNT_BASE = {16'h5A6B, 16'hABCD, 16'h1234};
  localparam logic [2:0]  NULL_SET = 3'b010;
  localparam logic [2:0]  OUT_SET  = 3'b101;

  always #5 clk_i = ~clk_i;

  timer_readback dut (.*);

  typedef struct packed {
    logic [7:0]      cmd;
    logic [1:0]      ch;
    logic [2:0]      n;
    logic [0:3][7:0] e;
    logic [3:0]      req;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{8'hC2, 2'd0, 3'd3, {8'hB4, 8'h34, 8'h12, 8'h00}, 4'd6},  // R6 both latched, status first
    '{8'hE4, 2'd1, 3'd2, {8'h67, 8'h32, 8'h00, 8'h00}, 4'd5},  // R5 status only, then live
    '{8'hD8, 2'd2, 3'd2, {8'h5A, 8'hA5, 8'h00, 8'h00}, 4'd7},  // R7 high-byte-only format
    '{8'hD2, 2'd0, 3'd4, {8'h34, 8'h12, 8'hCB, 8'hED}, 4'd4},  // R4 snapshot vs changed live
    '{8'hC3, 2'd0, 3'd2, {8'hCB, 8'hED, 8'h00, 8'h00}, 4'd2},  // R2 bit0 set: ignored
    '{8'h02, 2'd0, 3'd2, {8'hCB, 8'hED, 8'h00, 8'h00}, 4'd2},  // R2 not a read-back opcode
    '{8'hF2, 2'd0, 3'd2, {8'hCB, 8'hED, 8'h00, 8'h00}, 4'd2},  // R2 neither kind requested
    '{8'hC4, 2'd1, 3'd3, {8'h67, 8'hCD, 8'h32, 8'h00}, 4'd7},  // R7 low-byte-only snapshot
    '{8'hC8, 2'd2, 3'd3, {8'h90, 8'h5A, 8'hA5, 8'h00}, 4'd3}   // R3 channel 2 select bit
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] c);
    @(negedge clk_i);
    cmd_we_i = 1'b1;
    cmd_i = c;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] ch, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    rd_ch_i = ch;
    rd_en_i = 1'b1;
    #1 check(rd_data_o, exp, tag);
    @(posedge clk_i);
    #1 rd_en_i = 1'b0;
  endtask

  initial begin
    cfg_i = CFG_SET;
    null_cnt_i = NULL_SET;
    out_lvl_i = OUT_SET;
    count_i = CNT_BASE;
    repeat (3) @(posedge clk_i);
    #1 check(rd_data_o, 8'h34, "R1 output in reset");
    rst_ni = 1'b1;

    rd_chk(2'd0, 8'h34, "R1 first live byte low");
    rd_chk(2'd0, 8'h12, "R1 second live byte high");
    rd_chk(2'd1, 8'hCD, "R10 low-only live");
    rd_chk(2'd1, 8'hCD, "R10 low-only live repeat");
    rd_chk(2'd3, 8'h00, "R9 bad channel idle");

    for (int r = 0; r < 9; r++) begin
      count_i = CNT_BASE;
      do_cmd(TBL[r].cmd);
      count_i = ~CNT_BASE;
      for (int k = 0; k < int'(TBL[r].n); k++)
        rd_chk(TBL[r].ch, TBL[r].e[k], $sformatf("R%0d row %0d byte %0d", TBL[r].req, r, k));
    end

    // R3: all three channels, both kinds, one write
    count_i = CNT_BASE;
    do_cmd(8'hCE);
    count_i = ~CNT_BASE;
    rd_chk(2'd2, 8'h90, "R3 ch2 status");
    rd_chk(2'd2, 8'h5A, "R3 ch2 count");
    rd_chk(2'd0, 8'hB4, "R3 ch0 status");
    rd_chk(2'd0, 8'h34, "R3 ch0 count lo");
    rd_chk(2'd0, 8'h12, "R3 ch0 count hi");
    rd_chk(2'd1, 8'h67, "R3 ch1 status");
    rd_chk(2'd1, 8'hCD, "R3 ch1 count");

    // R8: repeated latches while unread are ignored
    count_i = CNT_BASE;
    do_cmd(8'hD2);
    count_i[15:0] = 16'h7777;
    do_cmd(8'hD2);
    rd_chk(2'd0, 8'h34, "R8 count kept lo");
    rd_chk(2'd0, 8'h12, "R8 count kept hi");
    do_cmd(8'hE2);
    out_lvl_i = 3'b000;
    null_cnt_i = 3'b111;
    do_cmd(8'hE2);
    rd_chk(2'd0, 8'hB4, "R8 status kept");
    rd_chk(2'd0, 8'h77, "R8 status released, live");
    out_lvl_i = OUT_SET;
    null_cnt_i = NULL_SET;
    rd_chk(2'd0, 8'h77, "R10 live hi");

    // R9: bad channel read leaves held status untouched
    count_i = CNT_BASE;
    do_cmd(8'hE2);
    rd_chk(2'd3, 8'h00, "R9 bad channel with latch");
    rd_chk(2'd0, 8'hB4, "R9 status survives");
    rd_chk(2'd0, 8'h34, "R9 then live lo");

    // R1: reset clears held snapshots
    do_cmd(8'hC2);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_chk(2'd0, 8'h34, "R1 reset drops latch");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule